// File: doc/BRIEF.md
# FSK and Dual-Tone Sample Synthesiser

This block generates the digital transmit waveform for a low-speed telephone-line modem. A single synthesiser, made of two phase accumulators that each address a sine table, serves two jobs. In keyed mode it switches one oscillator between a mark frequency and a space frequency, following the serial transmit bit. In tone mode it either adds two oscillators to form one of the 16 keypad dual-tone pairs, or runs one oscillator alone as a single melody tone.

All frequencies are derived from a 3.579545 MHz reference. A sample-enable strobe, one clock wide and pulsed once every `SAMP_DIV` reference periods, advances the synthesiser. The signed output word goes to a DAC outside the block. When the modulator is switched off, the output sits at mid-scale, which is code zero in two's complement.

Top module: `fsk_tone_mod`

## Requirements
- R1: After reset, `sample_o` is 0 and both phase accumulators are 0.
- R2: At any strobe where `mode_i[1]`=0, the next `sample_o` is 0 and both accumulators clear to 0. This holds whatever `mode_i[0]`, `tone_i` and `tx_bit_i` hold. After the modulator is enabled again, the first sample is taken at phase 0.
- R3: With `tone_i[7]`=0 and `mode_i`=2'b10, the block runs 75 bps keying: `tx_bit_i`=0 (space) gives 450 Hz and `tx_bit_i`=1 (mark) gives 390 Hz. The second accumulator stays at 0.
- R4: With `tone_i[7]`=0 and `mode_i`=2'b11, the block runs 1200 bps keying: space gives 2100 Hz and mark gives 1300 Hz.
- R5: The phase step for frequency f is round(f·2^24·SAMP_DIV/3579545). At each strobe, the sample taken from an accumulator is A·sin(2π(k+0.5)/256) within ±5 LSB. Here k is the top 8 bits of the accumulator before the step, and A = 2^(SAMP_W-1)-1.
- R6: A change between mark and space never resets the accumulator. Only the step size changes, so the phase stays continuous.
- R7: With `mode_i[1]`=1, `tone_i[7]`=1 and `tone_i[6]`=0, the output is half of the low-group sine plus half of the high-group sine, and it never exceeds ±A. The low group is selected by `tone_i[3:2]`: 0, 1, 2, 3 give 697, 770, 852, 941 Hz. The high group is selected by `tone_i[1:0]`: 0, 1, 2, 3 give 1209, 1336, 1477, 1633 Hz.
- R8: With `mode_i[1]`=1, `tone_i[7]`=1 and `tone_i[6]`=1, the output is the low-group tone alone at full amplitude, and the second accumulator is held at 0.
- R9: A new selection of mode, tone or bit takes effect only at the next strobe. Between strobes, `sample_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| samp_en_i | input | 1 | Sample strobe, one clock wide |
| mode_i | input | 2 | Bit 1 enables the modulator; bit 0 selects 1200 bps keying (1) or 75 bps keying (0) |
| tone_i | input | 8 | Bit 7 selects tone mode, bit 6 selects a single tone, bits 3:0 give the key index |
| tx_bit_i | input | 1 | Transmit data bit, 1 = mark |
| sample_o | output | SAMP_W | Signed sample word |

## Verification
Every result is due one clock after the strobe edge that samples the inputs. That edge registers the sine of the pre-step phase and advances the accumulators in the same cycle. The bench therefore raises the strobe on a falling edge and reads `sample_o` on the following falling edge. It then advances its own phase model by the step computed from R5. To confirm that nothing moves between strobes, the bench changes the inputs while the strobe is low, waits several clocks, and compares the output with the value it held before. The first sample after the change must then follow the new selection.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

  typedef enum logic [1:0] {SYN_OFF, SYN_FSK, SYN_DUAL, SYN_SINGLE} syn_mode_e;

  // round(f * 2^acc_w * div / ref)
  function automatic longint phase_inc(longint f_hz, longint div, longint ref_hz, int acc_w);
    return (f_hz * (longint'(1) << acc_w) * div + ref_hz / 2) / ref_hz;
  endfunction

  // rational sine approximation sampled at bin centres, 16u/(5-4u), u=t(1-t)
  function automatic int sine_val(int idx, int amp, int aw);
    longint half, p, n, d, v;
    half = longint'(1) << (aw - 1);
    p    = longint'(idx) % half;
    n    = (2 * p + 1) * (2 * half - 2 * p - 1);
    d    = 4 * half * half;
    v    = (longint'(amp) * 16 * n) / (5 * d - 4 * n);
    if (longint'(idx) >= half) v = -v;
    return int'(v);
  endfunction

endpackage

// File: rtl/fsk_freq_sel.sv
module fsk_freq_sel
  import fsk_tone_pkg::*;
#(
  parameter int     ACC_W    = 24,
  parameter longint REF_HZ   = 3579545,
  parameter longint SAMP_DIV = 448
) (
  input  logic [1:0]       mode_i,
  input  logic             tone_sel_i,
  input  logic             single_i,
  input  logic [3:0]       key_i,
  input  logic             tx_bit_i,
  output syn_mode_e        syn_o,
  output logic [ACC_W-1:0] inc_a_o,
  output logic [ACC_W-1:0] inc_b_o
);

  localparam logic [ACC_W-1:0] I_390  = ACC_W'(phase_inc(390,  SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_450  = ACC_W'(phase_inc(450,  SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_1300 = ACC_W'(phase_inc(1300, SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_2100 = ACC_W'(phase_inc(2100, SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_697  = ACC_W'(phase_inc(697,  SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_770  = ACC_W'(phase_inc(770,  SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_852  = ACC_W'(phase_inc(852,  SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_941  = ACC_W'(phase_inc(941,  SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_1209 = ACC_W'(phase_inc(1209, SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_1336 = ACC_W'(phase_inc(1336, SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_1477 = ACC_W'(phase_inc(1477, SAMP_DIV, REF_HZ, ACC_W));
  localparam logic [ACC_W-1:0] I_1633 = ACC_W'(phase_inc(1633, SAMP_DIV, REF_HZ, ACC_W));

  logic [ACC_W-1:0] row_inc, col_inc;

  always_comb begin
    unique case (key_i[3:2])
      2'd0:    row_inc = I_697;
      2'd1:    row_inc = I_770;
      2'd2:    row_inc = I_852;
      default: row_inc = I_941;
    endcase
    unique case (key_i[1:0])
      2'd0:    col_inc = I_1209;
      2'd1:    col_inc = I_1336;
      2'd2:    col_inc = I_1477;
      default: col_inc = I_1633;
    endcase
  end

  always_comb begin
    syn_o   = SYN_OFF;
    inc_a_o = '0;
    inc_b_o = '0;
    if (mode_i[1]) begin
      if (!tone_sel_i) begin
        syn_o   = SYN_FSK;
        inc_a_o = mode_i[0] ? (tx_bit_i ? I_1300 : I_2100)
                            : (tx_bit_i ? I_390  : I_450);
      end else if (single_i) begin
        syn_o   = SYN_SINGLE;
        inc_a_o = row_inc;
      end else begin
        syn_o   = SYN_DUAL;
        inc_a_o = row_inc;
        inc_b_o = col_inc;
      end
    end
  end

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clear_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] phase_o
);

  logic [ACC_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (step_i) phase_q <= clear_i ? '0 : phase_q + inc_i;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom
  import fsk_tone_pkg::*;
#(
  parameter int LUT_AW = 8,
  parameter int SAMP_W = 12
) (
  input  logic [LUT_AW-1:0]        addr_i,
  output logic signed [SAMP_W-1:0] val_o
);

  localparam int DEPTH = 1 << LUT_AW;
  localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

  logic signed [SAMP_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    assign tbl[i] = SAMP_W'(sine_val(i, AMP, LUT_AW));
  end

  assign val_o = tbl[addr_i];

endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod
  import fsk_tone_pkg::*;
#(
  parameter int     ACC_W    = 24,
  parameter int     LUT_AW   = 8,
  parameter int     SAMP_W   = 12,
  parameter longint REF_HZ   = 3579545,
  parameter longint SAMP_DIV = 448
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     samp_en_i,
  input  logic [1:0]               mode_i,
  input  logic [7:0]               tone_i,
  input  logic                     tx_bit_i,
  output logic signed [SAMP_W-1:0] sample_o
);

  localparam int N_CH = 2;

  syn_mode_e                syn;
  logic [ACC_W-1:0]         inc_c   [N_CH];
  logic [ACC_W-1:0]         phase_c [N_CH];
  logic                     clr_c   [N_CH];
  logic signed [SAMP_W-1:0] sin_c   [N_CH];
  logic signed [SAMP_W-1:0] mix;
  logic signed [SAMP_W-1:0] sample_q;
  logic [ACC_W-1:0]         phase_a, phase_b, inc_a;
  logic                     unused_tone;

  assign unused_tone = ^tone_i[5:4];

  fsk_freq_sel #(
    .ACC_W   (ACC_W),
    .REF_HZ  (REF_HZ),
    .SAMP_DIV(SAMP_DIV)
  ) u_sel (
    .mode_i    (mode_i),
    .tone_sel_i(tone_i[7]),
    .single_i  (tone_i[6]),
    .key_i     (tone_i[3:0]),
    .tx_bit_i  (tx_bit_i),
    .syn_o     (syn),
    .inc_a_o   (inc_c[0]),
    .inc_b_o   (inc_c[1])
  );

  // ch0 runs whenever enabled; ch1 only for dual tones
  assign clr_c[0] = (syn == SYN_OFF);
  assign clr_c[1] = (syn != SYN_DUAL);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    fsk_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (samp_en_i),
      .clear_i(clr_c[c]),
      .inc_i  (inc_c[c]),
      .phase_o(phase_c[c])
    );
    fsk_sine_rom #(.LUT_AW(LUT_AW), .SAMP_W(SAMP_W)) u_rom (
      .addr_i(phase_c[c][ACC_W-1 -: LUT_AW]),
      .val_o (sin_c[c])
    );
  end

  always_comb begin
    unique case (syn)
      SYN_FSK, SYN_SINGLE: mix = sin_c[0];
      SYN_DUAL:            mix = (sin_c[0] >>> 1) + (sin_c[1] >>> 1);
      default:             mix = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sample_q <= '0;
    else if (samp_en_i) sample_q <= mix;
  end

  assign sample_o = sample_q;
  assign phase_a  = phase_c[0];
  assign phase_b  = phase_c[1];
  assign inc_a    = inc_c[0];

endmodule

// File: rtl/fsk_tone_mod_chk.sv
module fsk_tone_mod_chk #(
  parameter int ACC_W  = 24,
  parameter int SAMP_W = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     samp_en_i,
  input logic [1:0]               mode_i,
  input logic [7:0]               tone_i,
  input logic signed [SAMP_W-1:0] sample_o,
  input logic [ACC_W-1:0]         phase_a,
  input logic [ACC_W-1:0]         phase_b,
  input logic [ACC_W-1:0]         inc_a
);

  localparam int AMP = (1 << (SAMP_W - 1)) - 1;

  p_off_mid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_en_i && !mode_i[1]) |=> (sample_o == '0));

  p_off_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_en_i && !mode_i[1]) |=> (phase_a == '0 && phase_b == '0));

  p_fsk_b_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_en_i && mode_i[1] && !tone_i[7]) |=> (phase_b == '0));

  p_phase_cont_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_en_i && mode_i[1] && !tone_i[7]) |=> (phase_a == $past(phase_a) + $past(inc_a)));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sample_o) <= AMP) && (int'(sample_o) >= -AMP));

  p_single_b_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_en_i && mode_i[1] && tone_i[7] && tone_i[6]) |=> (phase_b == '0));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_en_i |=> $stable(sample_o));

endmodule

bind fsk_tone_mod fsk_tone_mod_chk #(.ACC_W(ACC_W), .SAMP_W(SAMP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .samp_en_i(samp_en_i),
  .mode_i   (mode_i),
  .tone_i   (tone_i),
  .sample_o (sample_o),
  .phase_a  (phase_a),
  .phase_b  (phase_b),
  .inc_a    (inc_a)
);

// File: tb/fsk_tone_mod_tb.sv
module fsk_tone_mod_tb;

  localparam int     CLK_NS   = 10;
  localparam int     SAMP_W   = 12;
  localparam longint REF_HZ   = 3579545;
  localparam longint SAMP_DIV = 448;
  localparam longint MASK     = (longint'(1) << 24) - 1;
  localparam real    AMP      = 2047.0;
  localparam real    TOL      = 5.0;

  logic                     clk_i = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     samp_en_i = 1'b0;
  logic [1:0]               mode_i = 2'b00;
  logic [7:0]               tone_i = 8'h00;
  logic                     tx_bit_i = 1'b0;
  logic signed [SAMP_W-1:0] sample_o;

  int     n_chk = 0;
  int     n_fail = 0;
  longint ma = 0;
  longint mb = 0;

  always #(CLK_NS / 2) clk_i = ~clk_i;

  fsk_tone_mod u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .samp_en_i(samp_en_i),
    .mode_i   (mode_i),
    .tone_i   (tone_i),
    .tx_bit_i (tx_bit_i),
    .sample_o (sample_o)
  );

  function automatic longint inc_of(longint f);
    return (f * (longint'(1) << 24) * SAMP_DIV + REF_HZ / 2) / REF_HZ;
  endfunction

  function automatic real sref(longint ph);
    longint k;
    k = (ph >> 16) & 255;
    return AMP * $sin(6.283185307179586 * (real'(k) + 0.5) / 256.0);
  endfunction

  function automatic longint row_f(logic [1:0] r);
    case (r)
      2'd0: return 697;
      2'd1: return 770;
      2'd2: return 852;
      default: return 941;
    endcase
  endfunction

  function automatic longint col_f(logic [1:0] c);
    case (c)
      2'd0: return 1209;
      2'd1: return 1336;
      2'd2: return 1477;
      default: return 1633;
    endcase
  endfunction

  task automatic check_val(string rq, real act, real exp);
    n_chk++;
    if (act > exp + TOL || act < exp - TOL) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, int'(act), int'(exp));
    end
  endtask

  // one strobe; output checked one clock later against the bench phase model
  task automatic pulse(string rq);
    real exp;
    @(negedge clk_i) samp_en_i = 1'b1;
    @(negedge clk_i) samp_en_i = 1'b0;
    if (!mode_i[1]) begin
      exp = 0.0; ma = 0; mb = 0;
    end else if (!tone_i[7]) begin
      longint f;
      f = mode_i[0] ? (tx_bit_i ? 1300 : 2100) : (tx_bit_i ? 390 : 450);
      exp = sref(ma); ma = (ma + inc_of(f)) & MASK; mb = 0;
    end else if (tone_i[6]) begin
      exp = sref(ma); ma = (ma + inc_of(row_f(tone_i[3:2]))) & MASK; mb = 0;
    end else begin
      exp = sref(ma) / 2.0 + sref(mb) / 2.0;
      ma = (ma + inc_of(row_f(tone_i[3:2]))) & MASK;
      mb = (mb + inc_of(col_f(tone_i[1:0]))) & MASK;
    end
    check_val(rq, real'(sample_o), exp);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check_val("R1", real'(sample_o), 0.0);
    rst_ni = 1'b1;
    ma = 0; mb = 0;
    @(negedge clk_i);
    check_val("R1", real'(sample_o), 0.0);
  endtask

  task automatic t_fsk75();
    mode_i = 2'b10; tone_i = 8'h00; tx_bit_i = 1'b0;
    for (int i = 0; i < 40; i++) pulse("R3 space 450Hz R5");
    tx_bit_i = 1'b1;
    for (int i = 0; i < 40; i++) pulse("R3 mark 390Hz R5");
  endtask

  task automatic t_fsk1200();
    mode_i = 2'b11; tone_i = 8'h0f; tx_bit_i = 1'b0;
    for (int i = 0; i < 30; i++) pulse("R4 space 2100Hz");
    tx_bit_i = 1'b1;
    for (int i = 0; i < 30; i++) pulse("R4 mark 1300Hz");
  endtask

  task automatic t_phase_cont();
    mode_i = 2'b11; tone_i = 8'h00;
    for (int i = 0; i < 48; i++) begin
      tx_bit_i = ((i / 3) % 2) == 1;
      pulse("R6 keying keeps phase");
    end
  endtask

  task automatic t_disabled();
    mode_i = 2'b10; tx_bit_i = 1'b1;
    for (int i = 0; i < 5; i++) pulse("R3");
    mode_i = 2'b01; tone_i = 8'h85; tx_bit_i = 1'b0;
    for (int i = 0; i < 4; i++) pulse("R2 off mid-scale");
    mode_i = 2'b00; tone_i = 8'h00;
    for (int i = 0; i < 3; i++) pulse("R2 off mid-scale");
    mode_i = 2'b11;
    for (int i = 0; i < 6; i++) pulse("R2 restart at phase 0");
  endtask

  task automatic t_dual();
    mode_i = 2'b10;
    tone_i = 8'h80;
    for (int i = 0; i < 40; i++) pulse("R7 key 0 697+1209");
    tone_i = 8'h85;
    for (int i = 0; i < 40; i++) pulse("R7 key 5 770+1336");
    mode_i = 2'b11;
    tone_i = 8'h8f;
    for (int i = 0; i < 40; i++) pulse("R7 key 15 941+1633");
    tone_i = 8'h8b;
    for (int i = 0; i < 20; i++) pulse("R7 key 11 852+1633");
  endtask

  task automatic t_single();
    mode_i = 2'b10;
    tone_i = 8'hc8;
    for (int i = 0; i < 40; i++) pulse("R8 single 852Hz");
    tone_i = 8'hcf;
    for (int i = 0; i < 20; i++) pulse("R8 single 941Hz");
  endtask

  task automatic t_hold();
    real held;
    mode_i = 2'b11; tone_i = 8'h00; tx_bit_i = 1'b0;
    for (int i = 0; i < 5; i++) pulse("R4");
    held = real'(sample_o);
    mode_i = 2'b10; tone_i = 8'h85; tx_bit_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check_val("R9 hold between strobes", real'(sample_o), held);
    mode_i = 2'b01;
    repeat (3) @(negedge clk_i);
    check_val("R9 hold between strobes", real'(sample_o), held);
    mode_i = 2'b10;
    for (int i = 0; i < 5; i++) pulse("R9 new selection at strobe");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_fsk75();
    t_fsk1200();
    t_phase_cont();
    t_disabled();
    t_dual();
    t_single();
    t_hold();
    finish_run();
  end

endmodule